// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block sits beside the execute stage of a simple in-order core. It decides when the core leaves its normal instruction stream for a handler, and where that handler starts. Each cycle it looks at the exception causes raised by the instruction in execute. These are a data-side bus error, an instruction fetch bus error, a data translation miss, an illegal opcode, an external interrupt and a misaligned load or store. The unit finds misaligned accesses itself, from the access size and the low address bits. When several causes are present it takes only the most important one. The next cycle it asks the front end to flush and to fetch from a fixed handler address. The handler addresses are spaced 0x100 apart.

On entry the unit saves two values. The return address (EPCR) is the faulting instruction's PC. If that instruction sits in a branch delay slot, EPCR holds the PC of the branch before it, so the branch runs again on return. The effective-address register (EEAR) holds the data address that caused the fault. A return request sends the front end to the address in EPCR. Software may write EPCR before it returns.

Control is a four-state machine:
- BOOT is the state held in reset and for the first cycle after it. It emits the reset vector with a flush. Its transition is BOOT→RUN.
- RUN accepts causes and return requests. Its transitions are RUN→TAKE when a cause is present, RUN→RETURN when a return is requested and no cause is present, and RUN→RUN otherwise.
- TAKE lasts one cycle. It emits the chosen vector with a flush and ignores all causes. Its transition is TAKE→RUN.
- RETURN lasts one cycle. It emits EPCR without a flush. Its transition is RETURN→RUN.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, redirect_valid and flush are 1, redirect_pc is 0x100, and EPCR and EEAR read 0.
- R2: Each cause maps to a fixed handler address. Bus error (data or fetch) goes to 0x200, alignment to 0x600, illegal instruction to 0x700, external interrupt to 0x800 and data translation miss to 0x900.
- R3: mem_size encodes 00 byte, 01 half-word, 10 word and 11 unused. A half-word access (01) with mem_req set and mem_addr[0] = 1 (offset 1 or 3) raises an alignment exception. A half-word access at offset 0 or 2 does not.
- R4: A word access (10) with mem_addr[1:0] not equal to 00 raises an alignment exception. A byte access (00) or an unused size (11) never does.
- R5: data_bus_err loads EEAR with mem_addr. fetch_bus_err loads EEAR with ex_pc, and fetch_bus_err takes precedence when both are set. A translation miss or an alignment exception loads EEAR with mem_addr. An illegal instruction or an interrupt leaves EEAR unchanged.
- R6: On entry from an instruction outside a delay slot, EPCR receives ex_pc.
- R7: When causes coincide, the order is bus error, translation miss, illegal instruction, alignment, then external interrupt. An interrupt is taken only when no synchronous cause is present.
- R8: When ex_in_dslot is 1 on entry, EPCR receives ex_branch_pc instead of ex_pc.
- R9: A cause accepted in cycle N produces flush = 1 and redirect_valid = 1 with the vector in cycle N+1 only. Causes presented during that redirect cycle are ignored, so a cause held for two cycles enters its handler once.
- R10: A return request accepted in cycle N gives redirect_valid = 1, flush = 0 and redirect_pc = EPCR in cycle N+1. epcr_we writes epcr_wdata into EPCR with no redirect. A cause accepted in the same cycle wins over both the write and the return.
- R11: When ex_valid is 0, no cause is taken and EPCR and EEAR keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_pc | input | AW | PC of the instruction in execute |
| ex_in_dslot | input | 1 | Instruction in execute is in a branch delay slot |
| ex_branch_pc | input | AW | PC of the branch owning the delay slot |
| mem_req | input | 1 | Instruction is a load or store |
| mem_size | input | 2 | Access size (00 byte, 01 half, 10 word, 11 unused) |
| mem_addr | input | AW | Effective data address |
| data_bus_err | input | 1 | Data access hit an unimplemented address |
| fetch_bus_err | input | 1 | Instruction fetch hit an unimplemented address |
| dtlb_miss | input | 1 | Data translation miss |
| illegal_insn | input | 1 | Unimplemented opcode |
| ext_irq | input | 1 | External interrupt request |
| rfe_req | input | 1 | Return-from-exception request |
| epcr_we | input | 1 | Software write of EPCR |
| epcr_wdata | input | AW | Value for the EPCR write |
| redirect_valid | output | 1 | Front end must fetch from redirect_pc |
| redirect_pc | output | AW | Vector or return address |
| flush | output | 1 | Discard in-flight instructions |
| epcr | output | AW | Saved return address |
| eear | output | AW | Saved effective address |

## Verification
The bench sweeps every half-word and word offset and the byte and unused sizes. A design that checked only the lowest address bit, or that flagged byte accesses, would trap where it should not, or stay silent where it should trap. It stacks coincident causes in several combinations. A wrong priority order would show up as the wrong handler address or a stale EEAR. The bench also faults inside delay slots, where a wrong design would save the slot's own PC and skip the branch on return. It holds a cause across the redirect cycle, where a design that did not mask causes would flush twice. Finally it collides a return request and an EPCR write with an exception, where a wrong design would lose the captured PC or return instead of entering the handler.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // access size encoding on mem_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;

    // handler code; the vector address is this code shifted by VEC_SHIFT
    typedef enum logic [3:0] {
        VC_RESET = 4'h1,
        VC_BUS   = 4'h2,
        VC_ALIGN = 4'h6,
        VC_ILL   = 4'h7,
        VC_IRQ   = 4'h8,
        VC_TLB   = 4'h9
    } vec_code_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_RUN,
        ST_TAKE,
        ST_RETURN
    } exc_state_e;

    // cause slots, lowest index wins
    localparam int CI_BUS   = 0;
    localparam int CI_TLB   = 1;
    localparam int CI_ILL   = 2;
    localparam int CI_ALIGN = 3;
    localparam int CI_IRQ   = 4;
    localparam int NUM_CAUSE = 5;

    function automatic vec_code_e slot_code(input int idx);
        case (idx)
            CI_BUS:   return VC_BUS;
            CI_TLB:   return VC_TLB;
            CI_ILL:   return VC_ILL;
            CI_ALIGN: return VC_ALIGN;
            default:  return VC_IRQ;
        endcase
    endfunction

endpackage

// File: rtl/exc_align_check.sv
module exc_align_check
    import exc_pkg::*;
(
    input  logic       req,
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);

    always_comb begin
        misaligned = 1'b0;
        if (req) begin
            unique case (acc_size_e'(size))
                SZ_HALF: misaligned = addr_lo[0];
                SZ_WORD: misaligned = (addr_lo != 2'b00);
                SZ_BYTE: misaligned = 1'b0;
                SZ_NONE: misaligned = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/exc_cause_arbiter.sv
module exc_cause_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end

endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause_any,
    input  logic rfe_req,
    output logic take,
    output logic ret_sel,
    output logic redirect_valid,
    output logic flush
);

    exc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_RUN;
            ST_RUN: begin
                if (cause_any)    state_d = ST_TAKE;
                else if (rfe_req) state_d = ST_RETURN;
                else              state_d = ST_RUN;
            end
            ST_TAKE:   state_d = ST_RUN;
            ST_RETURN: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take           = 1'b0;
        ret_sel        = 1'b0;
        redirect_valid = 1'b0;
        flush          = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                redirect_valid = 1'b1;
                flush          = 1'b1;
            end
            ST_RUN: take = cause_any;
            ST_TAKE: begin
                redirect_valid = 1'b1;
                flush          = 1'b1;
            end
            ST_RETURN: begin
                redirect_valid = 1'b1;
                ret_sel        = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int VEC_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  vec_code_e     code_in,
    input  logic [AW-1:0] epcr_in,
    input  logic          eear_ld,
    input  logic [AW-1:0] eear_in,
    input  logic          epcr_we,
    input  logic [AW-1:0] epcr_wdata,
    input  logic          ret_sel,
    output logic [AW-1:0] redirect_pc,
    output logic [AW-1:0] epcr,
    output logic [AW-1:0] eear
);

    vec_code_e     code_q;
    logic [AW-1:0] epcr_q;
    logic [AW-1:0] eear_q;
    logic [AW-1:0] vec_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= VC_RESET;
            epcr_q <= '0;
            eear_q <= '0;
        end else begin
            if (take) begin
                code_q <= code_in;
                epcr_q <= epcr_in;
                if (eear_ld) eear_q <= eear_in;
            end else if (epcr_we) begin
                epcr_q <= epcr_wdata;
            end
        end
    end

    assign vec_addr    = AW'(code_q) << VEC_SHIFT;
    assign redirect_pc = ret_sel ? epcr_q : vec_addr;
    assign epcr        = epcr_q;
    assign eear        = eear_q;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int VEC_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_pc,
    input  logic          ex_in_dslot,
    input  logic [AW-1:0] ex_branch_pc,
    input  logic          mem_req,
    input  logic [1:0]    mem_size,
    input  logic [AW-1:0] mem_addr,
    input  logic          data_bus_err,
    input  logic          fetch_bus_err,
    input  logic          dtlb_miss,
    input  logic          illegal_insn,
    input  logic          ext_irq,
    input  logic          rfe_req,
    input  logic          epcr_we,
    input  logic [AW-1:0] epcr_wdata,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic          flush,
    output logic [AW-1:0] epcr,
    output logic [AW-1:0] eear
);

    logic                 misaligned;
    logic [NUM_CAUSE-1:0] cause_req;
    logic [NUM_CAUSE-1:0] cause_grant;
    logic                 cause_any;
    logic                 take;
    logic                 ret_sel;
    vec_code_e            code_sel;
    logic [AW-1:0]        epcr_cap;
    logic [AW-1:0]        eear_cap;
    logic                 eear_ld;

    exc_align_check u_align (
        .req        (mem_req),
        .size       (mem_size),
        .addr_lo    (mem_addr[1:0]),
        .misaligned (misaligned)
    );

    always_comb begin
        cause_req           = '0;
        cause_req[CI_BUS]   = ex_valid & (data_bus_err | fetch_bus_err);
        cause_req[CI_TLB]   = ex_valid & dtlb_miss;
        cause_req[CI_ILL]   = ex_valid & illegal_insn;
        cause_req[CI_ALIGN] = ex_valid & misaligned;
        cause_req[CI_IRQ]   = ex_valid & ext_irq;
    end

    exc_cause_arbiter #(.N(NUM_CAUSE)) u_arb (
        .req   (cause_req),
        .grant (cause_grant),
        .any   (cause_any)
    );

    // vector code, EEAR source and return address for the granted cause
    always_comb begin
        code_sel = VC_IRQ;
        eear_ld  = 1'b0;
        eear_cap = mem_addr;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            if (cause_grant[i]) code_sel = slot_code(i);
        end
        if (cause_grant[CI_BUS]) begin
            eear_ld  = 1'b1;
            eear_cap = fetch_bus_err ? ex_pc : mem_addr;
        end else if (cause_grant[CI_TLB] || cause_grant[CI_ALIGN]) begin
            eear_ld  = 1'b1;
            eear_cap = mem_addr;
        end
        epcr_cap = ex_in_dslot ? ex_branch_pc : ex_pc;
    end

    exc_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cause_any      (cause_any),
        .rfe_req        (rfe_req),
        .take           (take),
        .ret_sel        (ret_sel),
        .redirect_valid (redirect_valid),
        .flush          (flush)
    );

    exc_ctx_regs #(.AW(AW), .VEC_SHIFT(VEC_SHIFT)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .code_in     (code_sel),
        .epcr_in     (epcr_cap),
        .eear_ld     (eear_ld),
        .eear_in     (eear_cap),
        .epcr_we     (epcr_we),
        .epcr_wdata  (epcr_wdata),
        .ret_sel     (ret_sel),
        .redirect_pc (redirect_pc),
        .epcr        (epcr),
        .eear        (eear)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ex_valid,
    input logic          ex_in_dslot,
    input logic [AW-1:0] ex_branch_pc,
    input logic          mem_req,
    input logic [1:0]    mem_size,
    input logic [AW-1:0] mem_addr,
    input logic          data_bus_err,
    input logic          fetch_bus_err,
    input logic          dtlb_miss,
    input logic          illegal_insn,
    input logic          ext_irq,
    input logic          rfe_req,
    input logic          epcr_we,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_pc,
    input logic          flush,
    input logic [AW-1:0] epcr,
    input logic [AW-1:0] eear
);

    logic no_big;
    assign no_big = !data_bus_err && !fetch_bus_err && !dtlb_miss;

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_flush_redirects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> redirect_valid);

    assert_vector_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_pc == AW'(32'h100) || redirect_pc == AW'(32'h200) ||
                   redirect_pc == AW'(32'h600) || redirect_pc == AW'(32'h700) ||
                   redirect_pc == AW'(32'h800) || redirect_pc == AW'(32'h900)));

    assert_return_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && rfe_req && !ex_valid && !epcr_we)
        |=> (redirect_valid && !flush && redirect_pc == $past(epcr)));

    assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && ex_valid && mem_req && mem_size == 2'b10 &&
         mem_addr[1:0] != 2'b00 && no_big && !illegal_insn)
        |=> (flush && redirect_pc == AW'(32'h600) && eear == $past(mem_addr)));

    assert_half_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && ex_valid && mem_req && mem_size == 2'b01 &&
         mem_addr[0] && no_big && !illegal_insn)
        |=> (flush && redirect_pc == AW'(32'h600) && eear == $past(mem_addr)));

    assert_dslot_epcr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && ex_valid && illegal_insn && ex_in_dslot)
        |=> (epcr == $past(ex_branch_pc)));

    assert_irq_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && ex_valid && ext_irq && illegal_insn && no_big)
        |=> (redirect_pc == AW'(32'h700)));

    assert_invalid_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !ex_valid && !rfe_req)
        |=> (!redirect_valid && $stable(eear)));

endmodule

bind exc_entry_unit exc_entry_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ex_valid       (ex_valid),
    .ex_in_dslot    (ex_in_dslot),
    .ex_branch_pc   (ex_branch_pc),
    .mem_req        (mem_req),
    .mem_size       (mem_size),
    .mem_addr       (mem_addr),
    .data_bus_err   (data_bus_err),
    .fetch_bus_err  (fetch_bus_err),
    .dtlb_miss      (dtlb_miss),
    .illegal_insn   (illegal_insn),
    .ext_irq        (ext_irq),
    .rfe_req        (rfe_req),
    .epcr_we        (epcr_we),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .flush          (flush),
    .epcr           (epcr),
    .eear           (eear)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

    localparam int AW = 32;

    typedef struct packed {
        logic        v;
        logic        dbe;
        logic        fbe;
        logic        tlb;
        logic        ill;
        logic        irq;
        logic        req;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] pc;
        logic        ds;
        logic [31:0] bpc;
        logic        take;
        logic [31:0] vec;
        logic [31:0] epcr;
        logic [31:0] eear;
    } row_t;

    // v dbe fbe tlb ill irq req size addr pc ds bpc | take vec epcr eear
    localparam row_t TBL [0:20] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,32'h1001,32'h2000,1'b0,32'h0, 1'b1,32'h600,32'h2000,32'h1001},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,32'h1003,32'h2004,1'b0,32'h0, 1'b1,32'h600,32'h2004,32'h1003},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,32'h1002,32'h2008,1'b0,32'h0, 1'b0,32'h0,  32'h2004,32'h1003},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,32'h1002,32'h200c,1'b0,32'h0, 1'b1,32'h600,32'h200c,32'h1002},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,32'h1001,32'h2010,1'b0,32'h0, 1'b1,32'h600,32'h2010,32'h1001},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,32'h1003,32'h2014,1'b0,32'h0, 1'b1,32'h600,32'h2014,32'h1003},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,32'h1004,32'h2018,1'b0,32'h0, 1'b0,32'h0,  32'h2014,32'h1003},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,32'h1003,32'h201c,1'b0,32'h0, 1'b0,32'h0,  32'h2014,32'h1003},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,32'hEE000000,32'h2020,1'b0,32'h0, 1'b1,32'h200,32'h2020,32'hEE000000},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,32'h0,32'hEE000010,1'b0,32'h0, 1'b1,32'h200,32'hEE000010,32'hEE000010},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b10,32'hC0000000,32'h2024,1'b0,32'h0, 1'b1,32'h900,32'h2024,32'hC0000000},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,32'h0,32'h4,1'b0,32'h0, 1'b1,32'h700,32'h4,32'hC0000000},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,32'h0,32'h3000,1'b0,32'h0, 1'b1,32'h800,32'h3000,32'hC0000000},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,32'h0,32'h4,1'b1,32'h0, 1'b1,32'h700,32'h0,32'hC0000000},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,32'h1,32'h2034,1'b1,32'h2030, 1'b1,32'h600,32'h2030,32'h1},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b10,32'h5002,32'h2040,1'b0,32'h0, 1'b1,32'h200,32'h2040,32'h5002},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,2'b10,32'h6000,32'h2044,1'b0,32'h0, 1'b1,32'h900,32'h2044,32'h6000},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,2'b01,32'h7001,32'h2048,1'b0,32'h0, 1'b1,32'h700,32'h2048,32'h6000},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b01,32'h7003,32'h204c,1'b0,32'h0, 1'b1,32'h600,32'h204c,32'h7003},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,2'b10,32'h7001,32'h2050,1'b0,32'h0, 1'b0,32'h0,  32'h204c,32'h7003},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,32'h7001,32'h2054,1'b0,32'h0, 1'b0,32'h0,  32'h204c,32'h7003}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_valid = 1'b0;
    logic [AW-1:0] ex_pc = '0;
    logic          ex_in_dslot = 1'b0;
    logic [AW-1:0] ex_branch_pc = '0;
    logic          mem_req = 1'b0;
    logic [1:0]    mem_size = 2'b00;
    logic [AW-1:0] mem_addr = '0;
    logic          data_bus_err = 1'b0;
    logic          fetch_bus_err = 1'b0;
    logic          dtlb_miss = 1'b0;
    logic          illegal_insn = 1'b0;
    logic          ext_irq = 1'b0;
    logic          rfe_req = 1'b0;
    logic          epcr_we = 1'b0;
    logic [AW-1:0] epcr_wdata = '0;
    logic          redirect_valid;
    logic [AW-1:0] redirect_pc;
    logic          flush;
    logic [AW-1:0] epcr;
    logic [AW-1:0] eear;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_entry_unit #(.AW(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ex_valid       (ex_valid),
        .ex_pc          (ex_pc),
        .ex_in_dslot    (ex_in_dslot),
        .ex_branch_pc   (ex_branch_pc),
        .mem_req        (mem_req),
        .mem_size       (mem_size),
        .mem_addr       (mem_addr),
        .data_bus_err   (data_bus_err),
        .fetch_bus_err  (fetch_bus_err),
        .dtlb_miss      (dtlb_miss),
        .illegal_insn   (illegal_insn),
        .ext_irq        (ext_irq),
        .rfe_req        (rfe_req),
        .epcr_we        (epcr_we),
        .epcr_wdata     (epcr_wdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .flush          (flush),
        .epcr           (epcr),
        .eear           (eear)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ex_valid = 1'b0; ex_in_dslot = 1'b0; mem_req = 1'b0;
        data_bus_err = 1'b0; fetch_bus_err = 1'b0; dtlb_miss = 1'b0;
        illegal_insn = 1'b0; ext_irq = 1'b0; rfe_req = 1'b0; epcr_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int flushes;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "reset redirect_valid", 32'(redirect_valid), 32'h1);
        chk("R1", "reset flush", 32'(flush), 32'h1);
        chk("R1", "reset vector", redirect_pc, 32'h100);
        chk("R1", "reset epcr", epcr, 32'h0);
        chk("R1", "reset eear", eear, 32'h0);
        rst_n = 1'b1;
        chk("R1", "boot cycle vector", redirect_pc, 32'h100);
        chk("R1", "boot cycle flush", 32'(flush), 32'h1);
        @(negedge clk);
        chk("R1", "run after boot", 32'(redirect_valid), 32'h0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i <= 20; i++) begin
            ex_valid = TBL[i].v;   data_bus_err = TBL[i].dbe;
            fetch_bus_err = TBL[i].fbe; dtlb_miss = TBL[i].tlb;
            illegal_insn = TBL[i].ill; ext_irq = TBL[i].irq;
            mem_req = TBL[i].req;  mem_size = TBL[i].size;
            mem_addr = TBL[i].addr; ex_pc = TBL[i].pc;
            ex_in_dslot = TBL[i].ds; ex_branch_pc = TBL[i].bpc;
            @(negedge clk);
            chk("R9", $sformatf("row %0d flush", i), 32'(flush), 32'(TBL[i].take));
            chk("R11", $sformatf("row %0d redirect", i), 32'(redirect_valid), 32'(TBL[i].take));
            if (TBL[i].take)
                chk("R2/R7", $sformatf("row %0d vector", i), redirect_pc, TBL[i].vec);
            chk("R6/R8", $sformatf("row %0d epcr", i), epcr, TBL[i].epcr);
            chk("R5", $sformatf("row %0d eear", i), eear, TBL[i].eear);
            idle_inputs();
            @(negedge clk);
        end

        // R9: cause held across the redirect cycle enters once
        ex_valid = 1'b1; illegal_insn = 1'b1; ex_pc = 32'h80;
        flushes = 0;
        @(negedge clk);
        if (flush) flushes++;
        @(negedge clk);
        if (flush) flushes++;
        idle_inputs();
        repeat (2) begin
            @(negedge clk);
            if (flush) flushes++;
        end
        chk("R9", "single entry for held cause", 32'(flushes), 32'h1);
        chk("R9", "epcr after held cause", epcr, 32'h80);

        // R10: return to EPCR, no flush
        rfe_req = 1'b1;
        @(negedge clk);
        chk("R10", "return redirect", 32'(redirect_valid), 32'h1);
        chk("R10", "return no flush", 32'(flush), 32'h0);
        chk("R10", "return target", redirect_pc, 32'h80);
        idle_inputs();
        @(negedge clk);
        chk("R10", "back to run", 32'(redirect_valid), 32'h0);

        // R10: software EPCR write, then return
        epcr_we = 1'b1; epcr_wdata = 32'h1234;
        @(negedge clk);
        idle_inputs();
        chk("R10", "epcr write value", epcr, 32'h1234);
        chk("R10", "epcr write no redirect", 32'(redirect_valid), 32'h0);
        rfe_req = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R10", "return to written epcr", redirect_pc, 32'h1234);
        @(negedge clk);

        // R10: exception beats a same-cycle EPCR write
        epcr_we = 1'b1; epcr_wdata = 32'h5555;
        ex_valid = 1'b1; illegal_insn = 1'b1; ex_pc = 32'h90;
        @(negedge clk);
        idle_inputs();
        chk("R10", "capture beats write", epcr, 32'h90);
        chk("R10", "capture vector", redirect_pc, 32'h700);
        @(negedge clk);

        // R10: exception beats a same-cycle return
        rfe_req = 1'b1; ex_valid = 1'b1; illegal_insn = 1'b1; ex_pc = 32'hA0;
        @(negedge clk);
        idle_inputs();
        chk("R10", "cause beats return flush", 32'(flush), 32'h1);
        chk("R10", "cause beats return vector", redirect_pc, 32'h700);
        chk("R10", "cause beats return epcr", epcr, 32'hA0);
        @(negedge clk);

        // R1: reset in mid-run
        rst_n = 1'b0;
        #1;
        chk("R1", "mid-run reset vector", redirect_pc, 32'h100);
        chk("R1", "mid-run reset epcr", epcr, 32'h0);
        chk("R1", "mid-run reset eear", eear, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "run after second reset", 32'(redirect_valid), 32'h0);

        finish_run();
    end

endmodule